// File: doc/BRIEF.md
# Phase-Shift Full-Bridge Gate Sequencer

This block produces the four gate commands of a full H-bridge made of two complementary legs, A and B. It runs on phase-shift modulation. Leg A changes state on every oscillator period tick. Leg B changes state when the ramp-versus-demand comparator trips, or when the current limit fires. The delay from the tick to the trip therefore sets how long a diagonal pair conducts. Every output that turns on first waits through a single programmable dead interval. During that interval both outputs of its leg are off, so the switch node can slew to zero voltage. The output polarity toggles from one period to the next, which drives the transformer with a symmetric square wave.

A power-cycle flag is high from the tick that starts a conducting interval until that interval is terminated. Surrounding logic uses the flag to discharge a feed-forward ramp and to block over-long pulses. An inhibit input turns every output off at once and returns the block to its idle state. After reset, or after inhibit is released, nothing switches until the next period tick. That first period always starts with polarity 0.

Bit order used below: leg A is {a2,a1} with a1 as index 0, and leg B is {b2,b1} with b1 as index 0. In polarity 0 the period starts with a2 and b1 conducting, and a trip moves leg B to b2. In polarity 1 the period starts with a1 and b2, and a trip moves leg B to b1.

Top module: `pshift_bridge_seq`

## Requirements
- R1: While rst_n is low, all five outputs are 0. In any cycle where inhibit is high, all five outputs are 0 combinationally.
- R2: After reset, or after inhibit falls, a1, a2, b1, b2 and power_active stay 0 until the first period_tick is sampled.
- R3: The first tick after reset or inhibit starts polarity 0. a2 and b1 turn on exactly De cycles after the tick edge, where De = max(dead_cnt, MIN_DEAD).
- R4: A trip in polarity 0 turns b1 off at the edge that samples it. b2 turns on De cycles after that edge. Leg A is unaffected.
- R5: Each later tick toggles the polarity. In polarity 1, the tick turns a2 off and turns a1 on De cycles later, and a trip turns b2 off and turns b1 on De cycles later.
- R6: The same De applies to all four turn-ons. Values of dead_cnt below MIN_DEAD (2) are raised to MIN_DEAD.
- R7: A rising ilim_trip has exactly the same effect as phase_trip.
- R8: power_active goes high at the edge that samples a tick. It goes low at the edge that samples the first trip of that period.
- R9: A trip is ignored when power_active is low, and also in a cycle that also carries a tick. In both cases no output changes.
- R10: The two outputs of one leg are never high together. A tick that arrives while no trip has ended the period moves leg B to the start output of the new polarity. A new command to the partner output cancels a turn-on still waiting on dead time.
- R11: A trip that lands inside leg A's dead interval does not disturb it. Leg A and leg B each finish their own dead interval, counted from their own command edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| period_tick | input | 1 | One-cycle pulse marking each oscillator period |
| phase_trip | input | 1 | One-cycle pulse from the ramp-versus-demand comparator |
| ilim_trip | input | 1 | One-cycle pulse from the current-limit comparator |
| inhibit | input | 1 | Forces all outputs off and returns the block to idle |
| dead_cnt | input | DEAD_W | Dead interval in clock cycles, lower-bounded by MIN_DEAD |
| a1 | output | 1 | Leg A gate, index 0 |
| a2 | output | 1 | Leg A gate, index 1 |
| b1 | output | 1 | Leg B gate, index 0 |
| b2 | output | 1 | Leg B gate, index 1 |
| power_active | output | 1 | High while a conducting interval is in progress |

## Verification
Two things can fall in the same cycle: a period tick and a trip. The bench provokes this by driving both pulses on one edge. It expects the tick to win: the new period starts, power_active stays high, and leg B keeps the output it already has. A trip one cycle after a tick falls inside leg A's dead interval. There the bench expects each leg to finish its own dead interval, the two turn-ons landing one cycle apart. Two back-to-back ticks are also driven, and the bench expects the first, still-waiting leg A turn-on to be cancelled.

// File: rtl/pshift_pkg.sv
// Shared types for the phase-shift bridge sequencer.
// Assumes each leg has two outputs, with index 0 = x1 and index 1 = x2.
package pshift_pkg;

    // A leg command: go requests a change, and sel names the output to turn on.
    typedef struct packed {
        logic go;
        logic sel;
    } leg_cmd_t;

    localparam int NUM_LEGS = 2;

endpackage

// File: rtl/pshift_phase_ctrl.sv
// Period polarity, power-cycle flag and leg command generation.
// Assumes the tick and the trip inputs are single-cycle pulses. A tick has
// priority over a trip in the same cycle.
module pshift_phase_ctrl
    import pshift_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     inhibit,
    input  logic     tick,
    input  logic     trip,
    output leg_cmd_t cmd_a,
    output leg_cmd_t cmd_b,
    output logic     active
);

    logic started;
    logic pol;
    logic pol_next;
    logic trip_ok;

    // Polarity of the period a tick would start; the first one is polarity 0.
    always_comb begin
        pol_next = started ? ~pol : 1'b0;
        trip_ok  = trip & active & ~tick;
    end

    // Leg commands: leg A follows the tick, leg B follows the tick or an accepted trip.
    always_comb begin
        cmd_a.go  = tick & ~inhibit;
        cmd_a.sel = ~pol_next;
        cmd_b.go  = (tick | trip_ok) & ~inhibit;
        cmd_b.sel = tick ? pol_next : ~pol;
    end

    // Period state: polarity toggles on each tick, and the flag spans tick to trip.
    always_ff @(posedge clk) begin
        if (!rst_n || inhibit) begin
            started <= 1'b0;
            pol     <= 1'b0;
            active  <= 1'b0;
        end else if (tick) begin
            started <= 1'b1;
            pol     <= pol_next;
            active  <= 1'b1;
        end else if (trip_ok) begin
            active  <= 1'b0;
        end
    end

endmodule

// File: rtl/pshift_leg.sv
// One bridge leg: break-before-make with a dead interval counted in cycles.
// Assumes dead >= 1. A command to the output already targeted is ignored.
// A command to the partner output turns both off and restarts the wait.
module pshift_leg
    import pshift_pkg::*;
#(
    parameter int DEAD_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  leg_cmd_t          cmd,
    input  logic [DEAD_W-1:0] dead,
    output logic [1:0]        gate
);

    logic              tgt_vld;
    logic              tgt;
    logic              lit;
    logic              pend;
    logic [DEAD_W-1:0] cnt;
    logic              change;

    // A real change is a command toward an output not already targeted.
    always_comb change = cmd.go && !(tgt_vld && (tgt == cmd.sel));

    // Target, dead-interval countdown and turn-on.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            tgt_vld <= 1'b0;
            tgt     <= 1'b0;
            lit     <= 1'b0;
            pend    <= 1'b0;
            cnt     <= '0;
        end else if (change) begin
            tgt_vld <= 1'b1;
            tgt     <= cmd.sel;
            lit     <= 1'b0;
            pend    <= 1'b1;
            cnt     <= dead - 1'b1;
        end else if (pend) begin
            if (cnt == '0) begin
                lit  <= 1'b1;
                pend <= 1'b0;
            end else begin
                cnt <= cnt - 1'b1;
            end
        end
    end

    // Decode the lit target into a one-hot gate pair.
    always_comb gate = lit ? (tgt ? 2'b10 : 2'b01) : 2'b00;

endmodule

// File: rtl/pshift_bridge_seq.sv
// Top of the phase-shift full-bridge gate sequencer.
// Assumes synchronous single-cycle input pulses and a dead_cnt that is held
// steady while a dead interval is running.
module pshift_bridge_seq
    import pshift_pkg::*;
#(
    parameter int DEAD_W   = 8,
    parameter int MIN_DEAD = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              period_tick,
    input  logic              phase_trip,
    input  logic              ilim_trip,
    input  logic              inhibit,
    input  logic [DEAD_W-1:0] dead_cnt,
    output logic              a1,
    output logic              a2,
    output logic              b1,
    output logic              b2,
    output logic              power_active
);

    localparam logic [DEAD_W-1:0] MIN_V = DEAD_W'(MIN_DEAD);

    leg_cmd_t          leg_cmd  [NUM_LEGS];
    logic [1:0]        leg_gate [NUM_LEGS];
    logic [DEAD_W-1:0] dead_eff;
    logic              trip_any;
    logic              active_q;

    // Clamp the dead interval and merge the two trip sources.
    always_comb begin
        dead_eff = (dead_cnt < MIN_V) ? MIN_V : dead_cnt;
        trip_any = phase_trip | ilim_trip;
    end

    pshift_phase_ctrl u_ctrl (
        .clk    (clk),
        .rst_n  (rst_n),
        .inhibit(inhibit),
        .tick   (period_tick),
        .trip   (trip_any),
        .cmd_a  (leg_cmd[0]),
        .cmd_b  (leg_cmd[1]),
        .active (active_q)
    );

    for (genvar g = 0; g < NUM_LEGS; g++) begin : g_leg
        pshift_leg #(.DEAD_W(DEAD_W)) u_leg (
            .clk  (clk),
            .rst_n(rst_n),
            .clr  (inhibit),
            .cmd  (leg_cmd[g]),
            .dead (dead_eff),
            .gate (leg_gate[g])
        );
    end

    // Outputs, forced off at once by inhibit.
    always_comb begin
        a1           = leg_gate[0][0] & ~inhibit;
        a2           = leg_gate[0][1] & ~inhibit;
        b1           = leg_gate[1][0] & ~inhibit;
        b2           = leg_gate[1][1] & ~inhibit;
        power_active = active_q & ~inhibit;
    end

endmodule

// File: rtl/pshift_bridge_seq_chk.sv
// Checker for pshift_bridge_seq, attached by bind to every instance.
module pshift_bridge_seq_chk (
    input logic clk,
    input logic rst_n,
    input logic period_tick,
    input logic phase_trip,
    input logic ilim_trip,
    input logic inhibit,
    input logic a1,
    input logic a2,
    input logic b1,
    input logic b2,
    input logic power_active
);

    AST_LEG_A_EXCL: assert property (@(posedge clk) disable iff (!rst_n) !(a1 && a2)); // R10
    AST_LEG_B_EXCL: assert property (@(posedge clk) disable iff (!rst_n) !(b1 && b2)); // R10
    AST_INHIBIT_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        inhibit |-> !(a1 || a2 || b1 || b2 || power_active)); // R1
    AST_DEAD_A1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(a1) |-> (!$past(a2) && !$past(a2, 2))); // R6
    AST_DEAD_B2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(b2) |-> (!$past(b1) && !$past(b1, 2))); // R6
    AST_TICK_START: assert property (@(posedge clk) disable iff (!rst_n)
        (period_tick && !inhibit) |=> (power_active || inhibit)); // R8
    AST_TRIP_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
        ((phase_trip || ilim_trip) && power_active && !period_tick && !inhibit)
        |=> (!power_active && !b1 && !b2)); // R4

endmodule

bind pshift_bridge_seq pshift_bridge_seq_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .period_tick (period_tick),
    .phase_trip  (phase_trip),
    .ilim_trip   (ilim_trip),
    .inhibit     (inhibit),
    .a1          (a1),
    .a2          (a2),
    .b1          (b1),
    .b2          (b2),
    .power_active(power_active)
);

// File: tb/pshift_bridge_seq_tb.sv
// Bench: sweeps dead_cnt over 0..7 and runs a fixed sequence of periods for each value.
// Expected vectors are {a1,a2,b1,b2,power_active}.
module pshift_bridge_seq_tb;

    localparam int DW = 8;
    localparam int MIN_DEAD = 2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic period_tick = 1'b0;
    logic phase_trip = 1'b0;
    logic ilim_trip = 1'b0;
    logic inhibit = 1'b0;
    logic [DW-1:0] dead_cnt = '0;
    logic a1, a2, b1, b2, power_active;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    always #2.5 clk = ~clk;

    pshift_bridge_seq #(.DEAD_W(DW), .MIN_DEAD(MIN_DEAD)) u_dut (
        .clk(clk), .rst_n(rst_n), .period_tick(period_tick),
        .phase_trip(phase_trip), .ilim_trip(ilim_trip), .inhibit(inhibit),
        .dead_cnt(dead_cnt), .a1(a1), .a2(a2), .b1(b1), .b2(b2),
        .power_active(power_active)
    );

    function automatic logic [4:0] outs();
        return {a1, a2, b1, b2, power_active};
    endfunction

    task automatic chk(input string req, input logic [4:0] exp);
        checks++;
        if (outs() !== exp) begin
            errors++;
            $display("FAIL %s got=%b exp=%b t=%0t", req, outs(), exp, $time);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic pulse_tick();
        period_tick = 1'b1; @(negedge clk); period_tick = 1'b0;
    endtask

    task automatic pulse_trip(input logic use_ilim);
        if (use_ilim) ilim_trip = 1'b1; else phase_trip = 1'b1;
        @(negedge clk);
        ilim_trip = 1'b0; phase_trip = 1'b0;
    endtask

    // Overlap monitor for R10, sampled away from the active edge.
    always @(negedge clk) begin
        if (rst_n && ((a1 && a2) || (b1 && b2))) begin
            errors++;
            $display("FAIL R10 overlap got=%b exp=no-overlap", outs());
        end
    end

    // Watchdog: counts as a failed check and still prints the summary.
    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000) begin
            errors++;
            $display("FAIL watchdog got=%0d exp=<100000", cycles);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        for (int d = 0; d < 8; d++) begin
            int de;
            de = (d < MIN_DEAD) ? MIN_DEAD : d;
            dead_cnt = DW'(d);
            rst_n = 1'b0;
            step(2);
            chk("R1 reset", 5'b00000);
            rst_n = 1'b1;
            step(3);
            chk("R2 idle before tick", 5'b00000);

            // First period, polarity 0.
            pulse_tick();
            chk("R8 active on tick", 5'b00001);
            step(de - 1);
            chk("R6 still dead", 5'b00001);
            step(1);
            chk("R3 a2 b1 on", 5'b01101);
            step(2);

            // Trip: ilim for odd settings, phase comparator for even ones.
            pulse_trip(d[0]);
            chk(d[0] ? "R7 ilim trip b1 off" : "R4 trip b1 off", 5'b01000);
            step(de - 1);
            chk("R4 b2 waits", 5'b01000);
            step(1);
            chk("R4 b2 on", 5'b01010);

            // Second trip in the same period.
            pulse_trip(1'b0);
            chk("R9 second trip ignored", 5'b01010);
            step(2);
            chk("R9 second trip still ignored", 5'b01010);

            // Polarity 1.
            pulse_tick();
            chk("R5 a2 off", 5'b00011);
            step(de - 1);
            chk("R5 a1 waits", 5'b00011);
            step(1);
            chk("R5 a1 on", 5'b10011);
            pulse_trip(1'b0);
            chk("R5 b2 off", 5'b10000);
            step(de);
            chk("R5 b1 on", 5'b10100);

            // R11: trip inside leg A's dead interval.
            pulse_tick();
            chk("R11 a1 off", 5'b00101);
            pulse_trip(1'b0);
            chk("R11 b1 off", 5'b00000);
            step(de - 1);
            chk("R11 a2 on first", 5'b01000);
            step(1);
            chk("R11 b2 on next", 5'b01010);

            // R9: tick and trip in one cycle; the tick wins.
            period_tick = 1'b1; phase_trip = 1'b1;
            @(negedge clk);
            period_tick = 1'b0; phase_trip = 1'b0;
            chk("R9 coincident trip ignored", 5'b00011);
            step(de);
            chk("R9 coincident a1 on", 5'b10011);

            // R10: no trip in polarity 1, so the tick moves leg B.
            pulse_tick();
            chk("R10 untripped b2 off", 5'b00001);
            step(de);
            chk("R10 untripped b1 on", 5'b01101);

            // R10: cancel a waiting turn-on with back-to-back ticks.
            pulse_tick();
            chk("R10 first tick", 5'b00001);
            pulse_tick();
            chk("R10 second tick", 5'b00001);
            step(de - 1);
            chk("R10 a1 cancelled", 5'b00001);
            step(1);
            chk("R10 a2 on after cancel", 5'b01101);

            // Inhibit: outputs off at once; polarity restarts at 0.
            step(1);
            inhibit = 1'b1;
            #1;
            chk("R1 inhibit off", 5'b00000);
            @(negedge clk);
            inhibit = 1'b0;
            step(3);
            chk("R2 idle after inhibit", 5'b00000);
            pulse_tick();
            chk("R2 tick after inhibit", 5'b00001);
            step(de);
            chk("R3 polarity 0 after inhibit", 5'b01101);
        end
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule